// File: doc/BRIEF.md
# Power-Good Window Supervisor

This block decides when a regulated supply rail may be reported as good. It takes four comparator results, already brought into the clock domain. Two describe a narrow entry window and two describe a wider exit window around the nominal set-point. It turns them into a registered good flag, plus a companion pull-down enable for an open-drain, active-low pad. Assertion is slow and deliberate: the rail must sit inside the entry window without a break for a long qualification time, and that count may only begin once soft-start has reported completion. Deassertion is fast and looks only at the wider exit window. This gives hysteresis between the two windows.

Whenever the set-point code changes, the supervisor stops judging the rail for a fixed blanking time and holds its output. A further code change inside that time starts the blanking again. Removing the enable, or raising the fault input, drops the flag at once and clears every running count. The system must then signal soft-start completion again. All times are whole clock cycles given by parameters.

Top module: `pgood_supervisor`

## Requirements
- R1: After a synchronous reset, `pgood` is 0 and `pad_pull_dn` is 1.
- R2: While no soft-start completion has been seen since enable, `pgood` stays 0 even when the rail is inside the entry window.
- R3: After `ss_done` is sampled, `pgood` rises on the ASSERT_CYC-th following clock edge at which the rail is inside the entry window (`above_hi_in`=0 and `below_lo_in`=0) without a break, and not earlier.
- R4: A single sampled cycle outside the entry window during qualification restarts the ASSERT_CYC count from zero.
- R5: While good, the rail lying between the entry and exit limits (`above_hi_in`=1, `above_hi_out`=0) does not clear `pgood`.
- R6: While good, `pgood` falls on the DEASSERT_CYC-th consecutive edge at which the rail is outside the exit window (`above_hi_out`=1 or `below_lo_out`=1). A shorter excursion leaves it set.
- R7: A `ref_chg` pulse blanks monitoring at that edge and the MASK_CYC edges after it. `pgood` holds its value, and qualification counts start again from zero afterwards.
- R8: A `ref_chg` pulse during an active blanking interval restarts the full MASK_CYC interval.
- R9: `en`=0 or `fault`=1 drives `pgood` to 0 at the next edge. Good may return only after a new `ss_done` followed by a full qualification.
- R10: `pad_pull_dn` is always the inverse of `pgood`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Supervisor enable |
| fault | input | 1 | Fault indication, forces not-good |
| ss_done | input | 1 | Soft-start completion strobe |
| ref_chg | input | 1 | Set-point code change strobe |
| above_hi_in | input | 1 | Feedback above entry window upper limit |
| below_lo_in | input | 1 | Feedback below entry window lower limit |
| above_hi_out | input | 1 | Feedback above exit window upper limit |
| below_lo_out | input | 1 | Feedback below exit window lower limit |
| pgood | output | 1 | Registered power-good flag, active high |
| pad_pull_dn | output | 1 | Registered enable of the open-drain pull-down |

## Verification
A qualification counter that is off by one cycle, or that is not cleared, moves the rising or falling edge of `pgood` by exactly that amount. The bench therefore samples one edge before and one edge at each expected transition. A blanking timer that reloads wrongly, or ends early, lets `pgood` change while a code change is still pending. The nested-change test makes that visible tens of cycles ahead of the correct edge. A state machine that forgets the soft-start requirement after a fault shows up as `pgood` rising during a long in-window dwell with no new `ss_done`.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_OFF  = 2'd0,
    PG_QUAL = 2'd1,
    PG_GOOD = 2'd2
  } pg_state_t;
endpackage

// File: rtl/pg_window_decode.sv
module pg_window_decode (
  input  logic above_hi_in,
  input  logic below_lo_in,
  input  logic above_hi_out,
  input  logic below_lo_out,
  output logic inside_entry,
  output logic outside_exit
);
  // Narrow window used to qualify assertion, wide one to trigger removal.
  always_comb begin
    inside_entry = !above_hi_in && !below_lo_in;
    outside_exit = above_hi_out || below_lo_out;
  end
endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = run && !clr && (cnt == LAST);

  // Counts consecutive qualifying cycles; any gap starts over.
  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (hit)           cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R4/R6: count stays below its limit and never wraps
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R4: a cycle without the condition restarts the count
  a_r4_gap_clears: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
endmodule

// File: rtl/pg_mask_timer.sv
module pg_mask_timer #(
  parameter int MASK_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_chg,
  output logic masked
);
  localparam int MW = $clog2(MASK_CYC + 1);
  localparam logic [MW-1:0] LOAD = MW'(MASK_CYC);

  logic [MW-1:0] cnt;

  assign masked = ref_chg || (cnt != '0);

  // Every code change reloads the full blanking time.
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ref_chg)     cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  // R8: a change always restarts the full interval
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    ref_chg |=> cnt == LOAD);
  // R7: blanking counter stays within its range
  a_r7_mask_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      kill,
  input  logic      ss_done,
  input  logic      masked,
  input  logic      rise_hit,
  input  logic      fall_hit,
  output pg_state_t state,
  output logic      pgood,
  output logic      pad_pull_dn
);
  pg_state_t nxt;

  always_comb begin
    nxt = state;
    if (kill) nxt = PG_OFF;
    else begin
      unique case (state)
        PG_OFF:  if (ss_done) nxt = PG_QUAL;
        PG_QUAL: if (!masked && rise_hit) nxt = PG_GOOD;
        PG_GOOD: if (!masked && fall_hit) nxt = PG_QUAL;
        default: nxt = PG_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PG_OFF;
      pgood       <= 1'b0;
      pad_pull_dn <= 1'b1;
    end else begin
      state       <= nxt;
      pgood       <= (nxt == PG_GOOD);
      pad_pull_dn <= (nxt != PG_GOOD);
    end
  end

  // R2: no good indication while waiting for soft-start
  a_r2_off_not_good: assert property (@(posedge clk) disable iff (rst)
    (state == PG_OFF) |-> !pgood);
  // R10: pad drive is the complement of the flag
  a_r10_pad_inverse: assert property (@(posedge clk) disable iff (rst)
    pgood != pad_pull_dn);
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
  import pg_pkg::*;
#(
  parameter int ASSERT_CYC   = 660000,
  parameter int DEASSERT_CYC = 300,
  parameter int MASK_CYC     = 85000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fault,
  input  logic ss_done,
  input  logic ref_chg,
  input  logic above_hi_in,
  input  logic below_lo_in,
  input  logic above_hi_out,
  input  logic below_lo_out,
  output logic pgood,
  output logic pad_pull_dn
);
  logic      inside_entry, outside_exit;
  logic      masked, kill;
  logic      rise_hit, fall_hit;
  logic      rise_run, fall_run, rise_clr, fall_clr;
  pg_state_t state;

  assign kill = !en || fault;

  pg_window_decode u_dec (
    .above_hi_in (above_hi_in),
    .below_lo_in (below_lo_in),
    .above_hi_out(above_hi_out),
    .below_lo_out(below_lo_out),
    .inside_entry(inside_entry),
    .outside_exit(outside_exit)
  );

  pg_mask_timer #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .ref_chg(ref_chg),
    .masked (masked)
  );

  assign rise_clr = kill || masked || (state != PG_QUAL);
  assign fall_clr = kill || masked || (state != PG_GOOD);
  assign rise_run = inside_entry;
  assign fall_run = outside_exit;

  pg_qual_timer #(.LIMIT(ASSERT_CYC)) u_rise (
    .clk(clk), .rst(rst), .clr(rise_clr), .run(rise_run), .hit(rise_hit)
  );

  pg_qual_timer #(.LIMIT(DEASSERT_CYC)) u_fall (
    .clk(clk), .rst(rst), .clr(fall_clr), .run(fall_run), .hit(fall_hit)
  );

  pg_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .kill       (kill),
    .ss_done    (ss_done),
    .masked     (masked),
    .rise_hit   (rise_hit),
    .fall_hit   (fall_hit),
    .state      (state),
    .pgood      (pgood),
    .pad_pull_dn(pad_pull_dn)
  );

  // R9: disable or fault removes good at the next edge
  a_r9_kill_drops: assert property (@(posedge clk) disable iff (rst)
    kill |=> !pgood);
  // R7: output frozen while blanking is active
  a_r7_hold_in_mask: assert property (@(posedge clk) disable iff (rst)
    (masked && !kill) |=> $stable(pgood));
  // R3: a rise only follows a cycle inside the entry window
  a_r3_rise_in_window: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> $past(inside_entry));
endmodule

// File: tb/pgood_supervisor_test.sv
`timescale 1ns/1ps
module pgood_supervisor_test;
  localparam int A = 40;
  localparam int D = 6;
  localparam int M = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, fault = 1'b0, ss_done = 1'b0, ref_chg = 1'b0;
  logic above_hi_in = 1'b0, below_lo_in = 1'b1;
  logic above_hi_out = 1'b0, below_lo_out = 1'b1;
  logic pgood, pad_pull_dn;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pgood_supervisor #(.ASSERT_CYC(A), .DEASSERT_CYC(D), .MASK_CYC(M)) uut (
    .clk(clk), .rst(rst), .en(en), .fault(fault), .ss_done(ss_done),
    .ref_chg(ref_chg), .above_hi_in(above_hi_in), .below_lo_in(below_lo_in),
    .above_hi_out(above_hi_out), .below_lo_out(below_lo_out),
    .pgood(pgood), .pad_pull_dn(pad_pull_dn)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  // region: 0 inside entry, 1 band above entry, 2 above exit, 3 below exit
  task automatic set_rail(input int region);
    above_hi_in  = (region == 1) || (region == 2);
    above_hi_out = (region == 2);
    below_lo_in  = (region == 3);
    below_lo_out = (region == 3);
  endtask

  task automatic pulse_ss();
    ss_done = 1'b1; step(1); ss_done = 1'b0;
  endtask

  task automatic pulse_ref();
    ref_chg = 1'b1; step(1); ref_chg = 1'b0;
  endtask

  task automatic reach_good(input string req);
    set_rail(0);
    pulse_ss();
    step(A - 1);
    check(pgood, 1'b0, req, "one edge before qualification ends");
    step(1);
    check(pgood, 1'b1, req, "qualification complete");
    check(pad_pull_dn, 1'b0, "R10", "pad released when good");
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3); rst = 1'b0; step(1);
    check(pgood, 1'b0, "R1", "reset flag");
    check(pad_pull_dn, 1'b1, "R1", "reset pad pull-down");
  endtask

  task automatic t_no_softstart();
    en = 1'b1; set_rail(0); step(2 * A);
    check(pgood, 1'b0, "R2", "in window without soft-start");
  endtask

  task automatic t_assert();
    reach_good("R3");
  endtask

  task automatic t_glitch();
    en = 1'b0; step(2); en = 1'b1; step(1);
    set_rail(0); pulse_ss(); step(20);
    set_rail(3); step(1); set_rail(0);
    step(A - 1);
    check(pgood, 1'b0, "R4", "count restarted after glitch");
    step(1);
    check(pgood, 1'b1, "R4", "good after full count");
  endtask

  task automatic t_hysteresis();
    set_rail(1); step(3 * A);
    check(pgood, 1'b1, "R5", "between entry and exit limits");
    set_rail(2); step(D - 1); set_rail(1); step(2);
    check(pgood, 1'b1, "R6", "short excursion ignored");
    set_rail(2); step(D - 1);
    check(pgood, 1'b1, "R6", "one edge before drop");
    step(1);
    check(pgood, 1'b0, "R6", "drop after exit window dwell");
    check(pad_pull_dn, 1'b1, "R10", "pad pulls when not good");
    set_rail(0); step(A);
    check(pgood, 1'b1, "R3", "requalified without new soft-start");
  endtask

  task automatic t_mask_hold();
    set_rail(3); pulse_ref();
    step(M + D - 1);
    check(pgood, 1'b1, "R7", "held during blanking");
    step(1);
    check(pgood, 1'b0, "R7", "drop after blanking plus dwell");
  endtask

  task automatic t_mask_restart();
    set_rail(0);
    pulse_ref();
    step(9);
    pulse_ref();
    step(M + A - 1);
    check(pgood, 1'b0, "R8", "blanking restarted by second change");
    step(1);
    check(pgood, 1'b1, "R8", "good after restarted blanking");
  endtask

  task automatic t_kill();
    fault = 1'b1; step(1);
    check(pgood, 1'b0, "R9", "fault drops flag");
    fault = 1'b0; set_rail(0); step(2 * A);
    check(pgood, 1'b0, "R9", "no return without soft-start");
    reach_good("R9");
    en = 1'b0; step(1);
    check(pgood, 1'b0, "R9", "disable drops flag");
    en = 1'b1; step(2 * A);
    check(pgood, 1'b0, "R9", "re-enable waits for soft-start");
  endtask

  initial begin
    step(1);
    t_reset();
    t_no_softstart();
    t_assert();
    t_glitch();
    t_hysteresis();
    t_mask_hold();
    t_mask_restart();
    t_kill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule